// File: doc/BRIEF.md
# Four-Phase Clock-Crossing Command Handshake

This block carries one command, together with a data word, from a sending clock domain to a receiving clock domain. Each accepted request produces exactly one action in the receiving domain, whatever the ratio between the two clocks. The sender holds the word in a local register. It then signals the receiver on a single request line. The receiver answers on a single acknowledge line. Both lines pass through flip-flop synchronizers, and both edges of each line are waited for before the next step.

The sender machine has three states. SND_IDLE moves to SND_RAISE on an incoming request, and the word is captured on that move. SND_RAISE drives the request line high and moves to SND_DROP once the synchronized acknowledge is high. SND_DROP drives the request line low and moves back to SND_IDLE once the synchronized acknowledge is low. The receiver machine also has three states. RCV_WAIT moves to RCV_FIRE when the synchronized request is high, and the held word is copied to the output on that move. RCV_FIRE lasts one cycle, pulses the action output and always moves to RCV_ACK. RCV_ACK drives the acknowledge line high and moves back to RCV_WAIT once the synchronized request is low.

A user raises `s_req` with a word on `s_data` while `s_busy` is low. The word later appears on `r_data`, in the same receiver cycle as the one-cycle pulse on `r_fire`.

Top module: `four_phase_xfer`

## Requirements
- R1: While the resets are asserted and right after they are released, `s_busy` is 0, `r_fire` is 0 and `r_data` is all zeros.
- R2: When `s_req` is 1 while `s_busy` is 0 at a sender clock edge, the request is accepted and `s_busy` is 1 after that edge.
- R3: `s_req` and `s_data` are ignored while `s_busy` is 1. They cause no extra `r_fire` pulse and do not change the word that is delivered.
- R4: Each accepted request produces exactly one `r_fire` pulse, and that pulse is exactly one receiver cycle wide.
- R5: In the cycle `r_fire` is 1, `r_data` equals the `s_data` value sampled when the request was accepted. `r_data` keeps that value until the next pulse.
- R6: The request line falls only after the synchronized acknowledge has been seen high. The acknowledge line falls only after the synchronized request has been seen low.
- R7: `s_busy` returns to 0 only after the synchronized acknowledge has been seen low, so a new request cannot start while the previous acknowledge is still high.
- R8: The held word does not change while the request line is high.
- R9: R4 and R5 hold when the receiver clock is slower than, faster than, or unrelated to the sender clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_clk | input | 1 | Sender-domain clock |
| s_rst_n | input | 1 | Sender-domain asynchronous reset, active low |
| s_req | input | 1 | Request to deliver `s_data` |
| s_data | input | DATA_W | Word to deliver, sampled when the request is accepted |
| s_busy | output | 1 | High from acceptance until the handshake has fully closed |
| r_clk | input | 1 | Receiver-domain clock |
| r_rst_n | input | 1 | Receiver-domain asynchronous reset, active low |
| r_fire | output | 1 | One-cycle action pulse, one per accepted request |
| r_data | output | DATA_W | Delivered word, valid while `r_fire` is 1 and held afterwards |

## Verification
The bench builds the block with its defaults: an 8-bit word and two synchronizer stages. It runs twenty requests at each of three receiver clock periods: three times slower than the sender, about 1.7 times faster, and a non-integer ratio near 1.2. These three runs cover the cases where a one-way or two-way handshake would miss a request or act on it twice. Each word is computed from the phase and request index, so every run uses different bit patterns. During every transfer the bench keeps `s_req` high and feeds the inverted word for two extra cycles, to show that requests and data are ignored while busy.

// File: rtl/four_phase_pkg.sv
package four_phase_pkg;

    typedef enum logic [1:0] {
        SND_IDLE  = 2'd0,
        SND_RAISE = 2'd1,
        SND_DROP  = 2'd2
    } snd_state_t;

    typedef enum logic [1:0] {
        RCV_WAIT = 2'd0,
        RCV_FIRE = 2'd1,
        RCV_ACK  = 2'd2
    } rcv_state_t;

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fp_sender.sv
module fp_sender
    import four_phase_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [DATA_W-1:0] din,
    input  logic              ack_sync,
    output logic              cmd,
    output logic              busy,
    output logic [DATA_W-1:0] hold
);
    snd_state_t state, nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SND_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            SND_IDLE:  if (req)       nxt = SND_RAISE;
            SND_RAISE: if (ack_sync)  nxt = SND_DROP;
            SND_DROP:  if (!ack_sync) nxt = SND_IDLE;
            default:                  nxt = SND_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd  = (state == SND_RAISE);
        busy = (state != SND_IDLE);
    end

    // word holding register, loaded on acceptance only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        hold <= '0;
        else if (state == SND_IDLE && req) hold <= din;
    end
endmodule

// File: rtl/fp_receiver.sv
module fp_receiver
    import four_phase_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_sync,
    input  logic [DATA_W-1:0] hold,
    output logic              ack,
    output logic              fire,
    output logic [DATA_W-1:0] dout
);
    rcv_state_t state, nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RCV_WAIT;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            RCV_WAIT: if (cmd_sync)  nxt = RCV_FIRE;
            RCV_FIRE:                nxt = RCV_ACK;
            RCV_ACK:  if (!cmd_sync) nxt = RCV_WAIT;
            default:                 nxt = RCV_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        fire = (state == RCV_FIRE);
        ack  = (state == RCV_ACK);
    end

    // the held word is stable once the synchronized request is seen high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             dout <= '0;
        else if (state == RCV_WAIT && cmd_sync) dout <= hold;
    end
endmodule

// File: rtl/four_phase_xfer.sv
module four_phase_xfer #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              s_clk,
    input  logic              s_rst_n,
    input  logic              s_req,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_busy,
    input  logic              r_clk,
    input  logic              r_rst_n,
    output logic              r_fire,
    output logic [DATA_W-1:0] r_data
);
    logic              cmd;
    logic              ack;
    logic              cmd_at_r;
    logic              ack_at_s;
    logic [DATA_W-1:0] hold;

    fp_sender #(.DATA_W(DATA_W)) u_snd (
        .clk(s_clk), .rst_n(s_rst_n), .req(s_req), .din(s_data),
        .ack_sync(ack_at_s), .cmd(cmd), .busy(s_busy), .hold(hold)
    );

    bit_sync #(.STAGES(SYNC_STAGES)) u_cmd_sync (
        .clk(r_clk), .rst_n(r_rst_n), .d(cmd), .q(cmd_at_r)
    );

    bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(s_clk), .rst_n(s_rst_n), .d(ack), .q(ack_at_s)
    );

    fp_receiver #(.DATA_W(DATA_W)) u_rcv (
        .clk(r_clk), .rst_n(r_rst_n), .cmd_sync(cmd_at_r), .hold(hold),
        .ack(ack), .fire(r_fire), .dout(r_data)
    );
endmodule

// File: rtl/four_phase_xfer_chk.sv
module four_phase_xfer_chk #(
    parameter int DATA_W = 8
) (
    input logic              s_clk,
    input logic              s_rst_n,
    input logic              r_clk,
    input logic              r_rst_n,
    input logic              s_req,
    input logic              s_busy,
    input logic              cmd,
    input logic              ack_at_s,
    input logic [DATA_W-1:0] hold,
    input logic              ack,
    input logic              cmd_at_r,
    input logic              r_fire
);
    // sender domain
    assert_accept_R2: assert property (@(posedge s_clk) disable iff (!s_rst_n)
        (s_req && !s_busy) |=> s_busy);

    assert_cmd_hold_R6: assert property (@(posedge s_clk) disable iff (!s_rst_n)
        $fell(cmd) |-> $past(ack_at_s));

    assert_busy_release_R7: assert property (@(posedge s_clk) disable iff (!s_rst_n)
        $fell(s_busy) |-> !$past(ack_at_s));

    assert_hold_stable_R8: assert property (@(posedge s_clk) disable iff (!s_rst_n)
        (cmd && $past(cmd)) |-> $stable(hold));

    // receiver domain
    assert_ack_hold_R6: assert property (@(posedge r_clk) disable iff (!r_rst_n)
        $fell(ack) |-> !$past(cmd_at_r));

    assert_fire_pulse_R4: assert property (@(posedge r_clk) disable iff (!r_rst_n)
        r_fire |=> !r_fire);

    assert_fire_before_ack_R4: assert property (@(posedge r_clk) disable iff (!r_rst_n)
        $rose(ack) |-> $past(r_fire));
endmodule

bind four_phase_xfer four_phase_xfer_chk #(.DATA_W(DATA_W)) u_chk (
    .s_clk(s_clk), .s_rst_n(s_rst_n), .r_clk(r_clk), .r_rst_n(r_rst_n),
    .s_req(s_req), .s_busy(s_busy), .cmd(cmd), .ack_at_s(ack_at_s),
    .hold(hold), .ack(ack), .cmd_at_r(cmd_at_r), .r_fire(r_fire)
);

// File: tb/four_phase_xfer_tb.sv
`timescale 1ns/1ps
module four_phase_xfer_tb;
    localparam int DW = 8;

    logic          s_clk = 1'b0, r_clk = 1'b0;
    logic          s_rst_n = 1'b0, r_rst_n = 1'b0;
    logic          s_req = 1'b0;
    logic [DW-1:0] s_data = '0;
    logic          s_busy, r_fire;
    logic [DW-1:0] r_data;

    real r_half = 7.5;
    int  tests = 0, fails = 0;
    int  sent = 0, fired = 0;
    logic [DW-1:0] exp_q [0:63];
    logic prev_fire = 1'b0;

    always #2.5 s_clk = ~s_clk;
    always #(r_half) r_clk = ~r_clk;

    four_phase_xfer #(.DATA_W(DW), .SYNC_STAGES(2)) u_dut (
        .s_clk(s_clk), .s_rst_n(s_rst_n), .s_req(s_req), .s_data(s_data),
        .s_busy(s_busy), .r_clk(r_clk), .r_rst_n(r_rst_n),
        .r_fire(r_fire), .r_data(r_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // receiver monitor, sampled away from the receiver edge
    always @(negedge r_clk) begin
        if (r_rst_n) begin
            if (r_fire) begin
                chk(!prev_fire, "R4 pulse width", 2, 1);
                if (fired < 64)
                    chk(r_data == exp_q[fired], "R5/R9 word at pulse", int'(r_data), int'(exp_q[fired]));
                fired++;
            end
            prev_fire <= r_fire;
        end
    end

    task automatic send(input logic [DW-1:0] w);
        int waitc;
        @(negedge s_clk);
        s_req  = 1'b1;
        s_data = w;
        exp_q[sent] = w;
        sent++;
        @(negedge s_clk);
        chk(s_busy == 1'b1, "R2 busy after accept", int'(s_busy), 1);
        s_data = ~w;                   // R3: garbage while busy
        @(negedge s_clk);
        @(negedge s_clk);
        s_req = 1'b0;
        waitc = 0;
        while (s_busy && waitc < 2000) begin
            @(negedge s_clk);
            waitc++;
        end
        chk(fired == sent, "R4/R9 one pulse per request", fired, sent);
        chk(r_data == w, "R3/R5 delivered word kept", int'(r_data), int'(w));
    endtask

    initial begin
        #900000;
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge s_clk);
        chk(s_busy == 1'b0, "R1 busy in reset", int'(s_busy), 0);
        chk(r_fire == 1'b0, "R1 fire in reset", int'(r_fire), 0);
        s_rst_n = 1'b1;
        r_rst_n = 1'b1;
        repeat (6) @(negedge s_clk);
        chk(s_busy == 1'b0, "R1 busy after reset", int'(s_busy), 0);
        chk(r_data == '0, "R1 data after reset", int'(r_data), 0);
        chk(fired == 0, "R1 no pulse after reset", fired, 0);

        for (int ph = 0; ph < 3; ph++) begin
            r_half = (ph == 0) ? 7.5 : (ph == 1) ? 1.5 : 3.05;
            repeat (10) @(negedge s_clk);
            for (int k = 0; k < 20; k++)
                send(DW'((ph * 83 + k * 29 + 5) & 8'hFF));
            repeat (60) @(negedge s_clk);
            chk(fired == sent, "R3/R9 no extra pulse after phase", fired, sent);
            chk(s_busy == 1'b0, "R7 idle after phase", int'(s_busy), 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule